// File: doc/BRIEF.md
# Legacy-to-Framed Synthesizer Programming Bridge

This block lets a host that was written for an older frequency synthesizer keep running unchanged after that synthesizer is replaced by one with a different serial programming format. On its input side it listens to the host's three wires: a serial clock, a data line and a latch strobe. The host shifts a 16-bit tuning word in least significant bit first, sampled on rising clock edges. It then pulses the strobe to commit the word. All three host lines are treated as asynchronous. They are synchronized into the system clock domain and edge-detected there.

Each committed word becomes a three-frame programming sequence on the output side, which has a serial clock, data and an active-low frame sync. The first frame is a fixed control word. The other two carry the low and high 14-bit halves of a 28-bit frequency value, each with a 2-bit register-select prefix. That value is the captured word shifted left by a parameter, with zero fill. Frames go out most significant bit first and are timed for a receiver that samples on falling clock edges. The output clock idles high, and frame sync only ever moves while that clock is high.

The host cannot be stalled: the legacy interface has no ready line and therefore no back-pressure. A strobe that arrives during a sequence is absorbed by a one-deep pending slot instead. A plain `busy` level reports that a sequence is in flight.

Top module: `sdb_bridge`

## Requirements
- R1: After reset `dev_fsync` and `dev_sclk` are 1, and `busy` is 0.
- R2: Each rising edge of `host_sck` shifts `host_sdi` into a 16-bit register from the top, so the first bit sent lands in bit 0. Only a rising edge of `host_latch` copies that register into the holding register. Shifting without a strobe sends nothing, and a strobe without new shifting re-sends the held value.
- R3: Every accepted word W produces three frames in this order: `CTRL_WORD`, then {`FREQ_SEL`, F[13:0]}, then {`FREQ_SEL`, F[27:14]}. F is the 28-bit value of W shifted left by `FREQ_SHIFT` with zero fill.
- R4: A frame's bits go out bit 15 first. `dev_sdata` changes only at the start of a frame or in the cycle in which `dev_sclk` rises, so it is stable at every falling edge.
- R5: Whenever `dev_fsync` is 1, `dev_sclk` is 1. `dev_fsync` falls only while `dev_sclk` is high and was high in the cycle before.
- R6: Each frame has exactly 16 falling edges of `dev_sclk` while `dev_fsync` is low. `dev_fsync` rises after the 16th, with `dev_sclk` high.
- R7: Between two frames `dev_fsync` stays high for at least 2*`CLK_HALF` system cycles, which is one full output clock period.
- R8: `busy` rises within a few cycles of an accepted strobe and stays high through the third frame. It falls only after the post-frame gap. While `busy` is 0, `dev_fsync` is 1.
- R9: A strobe that arrives while `busy` is 1 stores its word in a one-deep pending slot. That word is sent after the current sequence ends. A later strobe that arrives before the slot is consumed replaces its content, so only the newest word is sent.
- R10: Within a frame every low phase of `dev_sclk` lasts exactly `CLK_HALF` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sck | input | 1 | Host serial clock; data is taken on its rising edge |
| host_sdi | input | 1 | Host serial data, least significant bit first |
| host_latch | input | 1 | Host commit strobe; acts on its rising edge |
| dev_sclk | output | 1 | Output serial clock, idles high |
| dev_sdata | output | 1 | Output serial data, most significant bit first |
| dev_fsync | output | 1 | Output frame sync, active low |
| busy | output | 1 | High while a programming sequence is in flight |

## Verification
The bench decodes each frame the way the receiver would, by shifting on falling edges. It compares the result with frames computed from the word the host sent, so any reversed bit order on either side shows up as a wrong word. It shifts a word with no strobe to catch a design that transfers on every shift, and it strobes with no new shift to catch one whose holding register follows the shift register. It sends two strobes during one sequence to catch a pending slot that keeps the older word or sends both. It also measures clock phases, frame-sync gaps, falling-edge counts and data changes, which would expose a frame sync that moves while the clock is low or a 15- or 17-edge frame.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int WORD_W = 16;
  localparam int FREQ_W = 28;
  localparam int HALF_W = FREQ_W / 2;
  localparam int SEL_W  = WORD_W - HALF_W;
  localparam int FRAMES = 3;
  localparam int IDX_W  = $clog2(FRAMES);
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    TX_IDLE, TX_SETUP, TX_HIGH, TX_LOW, TX_TAIL, TX_GAP
  } tx_state_t;

  function automatic logic [WORD_W-1:0] frame_word(
    input logic [WORD_W-1:0] cap,
    input logic [IDX_W-1:0]  idx,
    input logic [WORD_W-1:0] ctrl,
    input logic [SEL_W-1:0]  sel,
    input int unsigned       sh
  );
    logic [FREQ_W-1:0] f;
    f = FREQ_W'(cap) << sh;
    case (idx)
      IDX_W'(0): frame_word = ctrl;
      IDX_W'(1): frame_word = {sel, f[HALF_W-1:0]};
      default:   frame_word = {sel, f[FREQ_W-1:HALF_W]};
    endcase
  endfunction
endpackage

// File: rtl/sdb_sync.sv
module sdb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdb_host_rx.sv
module sdb_host_rx
  import sdb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sck,
  input  logic              host_sdi,
  input  logic              host_latch,
  output logic              cap_valid,
  output logic [WORD_W-1:0] cap_word
);
  logic [2:0]        synced;
  logic              sck_s, sdi_s, lat_s;
  logic              sck_d, lat_d;
  logic [WORD_W-1:0] shreg;

  sdb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({host_latch, host_sdi, host_sck}),
    .q    (synced)
  );

  assign sck_s = synced[0];
  assign sdi_s = synced[1];
  assign lat_s = synced[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      lat_d     <= 1'b0;
      shreg     <= '0;
      cap_word  <= '0;
      cap_valid <= 1'b0;
    end else begin
      sck_d     <= sck_s;
      lat_d     <= lat_s;
      cap_valid <= 1'b0;
      if (sck_s && !sck_d) shreg <= {sdi_s, shreg[WORD_W-1:1]};
      if (lat_s && !lat_d) begin
        cap_word  <= shreg;
        cap_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdb_word_seq.sv
module sdb_word_seq
  import sdb_pkg::*;
#(
  parameter logic [WORD_W-1:0] CTRL_WORD  = 16'h2000,
  parameter logic [SEL_W-1:0]  FREQ_SEL   = 2'b01,
  parameter int unsigned       FREQ_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              tx_done,
  output logic              tx_start,
  output logic [WORD_W-1:0] tx_word,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

  logic [WORD_W-1:0] active_w, pend_w, nxt_pend_w;
  logic [IDX_W-1:0]  idx;
  logic              pend_v, nxt_pend_v, park;

  always_comb begin
    park       = cap_valid && busy;
    nxt_pend_v = park || pend_v;
    nxt_pend_w = park ? cap_word : pend_w;
    tx_word    = frame_word(active_w, idx, CTRL_WORD, FREQ_SEL, FREQ_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_w <= '0;
      pend_w   <= '0;
      pend_v   <= 1'b0;
      idx      <= '0;
      busy     <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      pend_v   <= nxt_pend_v;
      pend_w   <= nxt_pend_w;
      if (cap_valid && !busy) begin
        active_w <= cap_word;
        idx      <= '0;
        busy     <= 1'b1;
        tx_start <= 1'b1;
      end else if (tx_done) begin
        if (idx == LAST_IDX) begin
          if (nxt_pend_v) begin
            active_w <= nxt_pend_w;
            pend_v   <= 1'b0;
            idx      <= '0;
            tx_start <= 1'b1;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          idx      <= idx + 1'b1;
          tx_start <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdb_frame_tx.sv
module sdb_frame_tx
  import sdb_pkg::*;
#(
  parameter int CLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              sdata,
  output logic              fsync,
  output logic              done
);
  localparam int TMR_W = $clog2(2 * CLK_HALF) + 1;
  localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(CLK_HALF - 1);
  localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(2 * CLK_HALF - 1);

  tx_state_t         state;
  logic [TMR_W-1:0]  tmr;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] shw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      tmr     <= '0;
      bit_idx <= '0;
      shw     <= '0;
      sclk    <= 1'b1;
      sdata   <= 1'b0;
      fsync   <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == TX_IDLE) begin
        if (start) begin
          shw     <= word;
          sdata   <= word[WORD_W-1];
          bit_idx <= BIT_W'(WORD_W - 1);
          fsync   <= 1'b0;
          tmr     <= HALF_LD;
          state   <= TX_SETUP;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        case (state)
          TX_SETUP, TX_HIGH: begin
            sclk  <= 1'b0;
            tmr   <= HALF_LD;
            state <= TX_LOW;
          end
          TX_LOW: begin
            sclk <= 1'b1;
            tmr  <= HALF_LD;
            if (bit_idx == '0) begin
              state <= TX_TAIL;
            end else begin
              bit_idx <= bit_idx - 1'b1;
              sdata   <= shw[bit_idx-1'b1];
              state   <= TX_HIGH;
            end
          end
          TX_TAIL: begin
            fsync <= 1'b1;
            tmr   <= GAP_LD;
            state <= TX_GAP;
          end
          default: begin
            done  <= 1'b1;
            state <= TX_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sdb_bridge.sv
module sdb_bridge
  import sdb_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                CLK_HALF    = 4,
  parameter int unsigned       FREQ_SHIFT  = 8,
  parameter logic [WORD_W-1:0] CTRL_WORD   = 16'h2000,
  parameter logic [SEL_W-1:0]  FREQ_SEL    = 2'b01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_sck,
  input  logic host_sdi,
  input  logic host_latch,
  output logic dev_sclk,
  output logic dev_sdata,
  output logic dev_fsync,
  output logic busy
);
  logic              cap_valid, tx_start, tx_done;
  logic [WORD_W-1:0] cap_word, tx_word;

  sdb_host_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sck  (host_sck),
    .host_sdi  (host_sdi),
    .host_latch(host_latch),
    .cap_valid (cap_valid),
    .cap_word  (cap_word)
  );

  sdb_word_seq #(
    .CTRL_WORD (CTRL_WORD),
    .FREQ_SEL  (FREQ_SEL),
    .FREQ_SHIFT(FREQ_SHIFT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_valid(cap_valid),
    .cap_word (cap_word),
    .tx_done  (tx_done),
    .tx_start (tx_start),
    .tx_word  (tx_word),
    .busy     (busy)
  );

  sdb_frame_tx #(.CLK_HALF(CLK_HALF)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .start(tx_start),
    .word (tx_word),
    .sclk (dev_sclk),
    .sdata(dev_sdata),
    .fsync(dev_fsync),
    .done (tx_done)
  );
endmodule

// File: rtl/sdb_bridge_chk.sv
module sdb_bridge_chk #(
  parameter int CLK_HALF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic dev_sclk,
  input logic dev_sdata,
  input logic dev_fsync,
  input logic busy
);
  logic       p_fs, p_sc, seen_end;
  logic [7:0] fall_cnt;
  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_fs     <= 1'b1;
      p_sc     <= 1'b1;
      seen_end <= 1'b0;
      fall_cnt <= '0;
      hi_cnt   <= '0;
      lo_cnt   <= '0;
    end else begin
      p_fs <= dev_fsync;
      p_sc <= dev_sclk;
      if (!p_fs && dev_fsync) seen_end <= 1'b1;
      if (p_fs && !dev_fsync) fall_cnt <= '0;
      else if (p_sc && !dev_sclk && !dev_fsync) fall_cnt <= fall_cnt + 1'b1;
      if (!dev_fsync) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (dev_sclk) lo_cnt <= '0;
      else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assert_idle_clock_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fsync |-> dev_sclk);

  assert_sync_fall_clock_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_fsync) |-> (dev_sclk && $past(dev_sclk)));

  assert_data_stable_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_sclk) |-> $stable(dev_sdata));

  assert_sixteen_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_fsync) |-> (fall_cnt == 8'd16 && dev_sclk));

  assert_frame_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dev_fsync) && seen_end) |-> (hi_cnt >= 16'(2 * CLK_HALF)));

  assert_idle_no_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dev_fsync);

  assert_low_phase_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_sclk) && !dev_fsync) |-> (lo_cnt == 16'(CLK_HALF)));
endmodule

bind sdb_bridge sdb_bridge_chk #(.CLK_HALF(CLK_HALF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dev_sclk (dev_sclk),
  .dev_sdata(dev_sdata),
  .dev_fsync(dev_fsync),
  .busy     (busy)
);

// File: tb/sdb_bridge_bench.sv
module sdb_bridge_bench;
  localparam int          CLK_HALF   = 4;
  localparam int unsigned FREQ_SHIFT = 8;
  localparam logic [15:0] CTRL       = 16'h2000;
  localparam logic [1:0]  SEL        = 2'b01;
  localparam int          HOST_HALF  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sck = 1'b0, host_sdi = 1'b0, host_latch = 1'b0;
  logic dev_sclk, dev_sdata, dev_fsync, busy;

  always #10 clk = ~clk;

  sdb_bridge #(
    .CLK_HALF  (CLK_HALF),
    .FREQ_SHIFT(FREQ_SHIFT),
    .CTRL_WORD (CTRL),
    .FREQ_SEL  (SEL)
  ) u_sdb_bridge (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sck  (host_sck),
    .host_sdi  (host_sdi),
    .host_latch(host_latch),
    .dev_sclk  (dev_sclk),
    .dev_sdata (dev_sdata),
    .dev_fsync (dev_fsync),
    .busy      (busy)
  );

  int checks = 0, errors = 0, frames = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  bit has_pend = 1'b0;
  logic [15:0] pend_w;

  function automatic logic [15:0] exp_word(input logic [15:0] w, input int i);
    logic [27:0] f;
    f = {12'h000, w} << FREQ_SHIFT;
    if (i == 0) return CTRL;
    if (i == 1) return {SEL, f[13:0]};
    return {SEL, f[27:14]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_triple(input logic [15:0] w);
    for (int i = 0; i < 3; i++) exp_q.push_back(exp_word(w, i));
  endtask

  // receiver model, sampled away from the active edge
  logic p_s = 1'b1, p_f = 1'b1, p_d = 1'b0, seen_end = 1'b0;
  logic [15:0] rx_sh;
  int rx_bits = 0, lo_run = 0, hi_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_f && !dev_fsync) begin
        check(p_s && dev_sclk, "R5", "clock high at frame-sync fall", {31'd0, dev_sclk}, 1);
        if (seen_end) check(hi_run >= 2 * CLK_HALF, "R7", "frame gap", hi_run, 2 * CLK_HALF);
        rx_bits = 0;
      end
      if (p_s && !dev_sclk && !dev_fsync) begin
        check(dev_sdata == p_d, "R4", "data moved at falling edge", {31'd0, dev_sdata}, {31'd0, p_d});
        rx_sh = {rx_sh[14:0], dev_sdata};
        rx_bits++;
      end
      if (!p_s && dev_sclk && !dev_fsync)
        check(lo_run == CLK_HALF, "R10", "low phase length", lo_run, CLK_HALF);
      if (!p_f && dev_fsync) begin
        seen_end = 1'b1;
        frames++;
        check(rx_bits == 16, "R6", "falling edges per frame", rx_bits, 16);
        check(busy, "R8", "busy during frame", {31'd0, busy}, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected frame", {16'd0, rx_sh}, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rx_sh == e, "R3", "frame word", {16'd0, rx_sh}, {16'd0, e});
          if (exp_q.size() == 0 && has_pend) begin
            push_triple(pend_w);
            has_pend = 1'b0;
          end
        end
      end
      if (!dev_sclk) lo_run++; else lo_run = 0;
      if (dev_fsync) hi_run++; else hi_run = 0;
      p_s = dev_sclk;
      p_f = dev_fsync;
      p_d = dev_sdata;
    end
  end

  task automatic shift_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      host_sdi = w[i];
      repeat (HOST_HALF) @(negedge clk);
      host_sck = 1'b1;
      repeat (HOST_HALF) @(negedge clk);
      host_sck = 1'b0;
    end
    repeat (HOST_HALF) @(negedge clk);
  endtask

  task automatic strobe(input logic [15:0] w);
    bit was_busy;
    @(negedge clk);
    was_busy = busy;
    if (!was_busy) push_triple(w);
    else begin
      has_pend = 1'b1;
      pend_w   = w;
    end
    host_latch = 1'b1;
    repeat (HOST_HALF) @(negedge clk);
    host_latch = 1'b0;
    repeat (HOST_HALF) @(negedge clk);
    if (!was_busy) check(busy, "R8", "busy after accepted strobe", {31'd0, busy}, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    check(!busy && dev_fsync && dev_sclk, "R8", "idle lines after sequence",
          {29'd0, busy, dev_fsync, dev_sclk}, 3'b011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f0;
    void'($urandom(32'h5DB1));
    repeat (5) @(negedge clk);
    check(dev_fsync && dev_sclk && !busy, "R1", "reset state",
          {29'd0, dev_fsync, dev_sclk, busy}, 3'b110);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(dev_fsync && dev_sclk && !busy, "R1", "state after reset release",
          {29'd0, dev_fsync, dev_sclk, busy}, 3'b110);

    // R3 directed corner words
    shift_word(16'h0001); strobe(16'h0001); wait_idle();
    shift_word(16'hFFFF); strobe(16'hFFFF); wait_idle();
    shift_word(16'h8000); strobe(16'h8000); wait_idle();

    // R2 shift without strobe has no effect; strobe alone re-sends held word
    f0 = frames;
    shift_word(16'hA5A5);
    repeat (400) @(negedge clk);
    check(frames == f0 && !busy, "R2", "shift without strobe sent frames", frames - f0, 0);
    strobe(16'hA5A5); wait_idle();
    f0 = frames;
    strobe(16'hA5A5); wait_idle();
    check(frames == f0 + 3, "R2", "strobe-only resend frame count", frames - f0, 3);

    // R9 two strobes during one sequence: only the newer one follows
    f0 = frames;
    shift_word(16'h1234); strobe(16'h1234);
    shift_word(16'h5678); strobe(16'h5678);
    shift_word(16'h9ABC); strobe(16'h9ABC);
    wait_idle();
    check(frames == f0 + 6, "R9", "frames after overwrite", frames - f0, 6);

    // random bursts of one to three words
    for (int it = 0; it < 16; it++) begin
      int n;
      n = int'($urandom_range(1, 3));
      for (int k = 0; k < n; k++) begin
        logic [15:0] w;
        w = 16'($urandom);
        shift_word(w);
        strobe(w);
      end
      wait_idle();
      repeat (int'($urandom_range(0, 30))) @(negedge clk);
    end

    check(exp_q.size() == 0 && !has_pend, "R9", "expected frames left over",
          exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule